// File: doc/BRIEF.md
# Pre-add multiply arithmetic slice

This block is a pipelined arithmetic slice. It first combines two operands in a pre-adder, either as a sum or as a difference. It then multiplies that result by a third operand. The product goes on to a post-adder, which sums three routed terms and a carry-in into a 48-bit result. The post-adder's three terms (called X, Y and Z here) come from multiplexers set by a 7-bit routing word. The product appears on the output only when that word routes it there. An all-zero routing word therefore yields only the carry-in, whatever the operands are.

Every register stage has its own clock enable and its own synchronous reset. The stages are the A, D, B (two deep), C, pre-adder, product and result registers. Reset takes priority over enable. A 5-bit front mode word controls two things: whether the pre-adder adds or subtracts, and which B register feeds the multiplier. The front mode word, the routing word and the carry-in are not registered. They act on the stage they feed in the same cycle.

Top module: `premul_slice`

## Requirements
- R1: After every stage reset is held for at least one clock edge, `p_out` reads 0.
- R2: With `route_mode` = 7'b0000101, `front_mode[3]` = 1 and `front_mode[4]` = 0, operands held steady give `p_out` = sext48((D − A[24:0]) mod 2^25, as signed 25-bit × signed B) + `carry_in`, four edges after the operands are applied.
- R3: With `front_mode[3]` = 0, the pre-adder forms D + A[24:0] (wrapping at 25 bits) in place of the difference.
- R4: `route_mode` = 7'b0000000 makes X, Y and Z zero, so `p_out` = `carry_in` whatever the operands.
- R5: `route_mode[6:4]` = 3'b011 selects the registered C operand as Z; with 7'b0110101, `p_out` = C + product + `carry_in`.
- R6: `route_mode[6:4]` = 3'b010 selects the current `p_out` as Z; with 7'b0100101, each enabled edge adds product + `carry_in` to `p_out`.
- R7: `route_mode[1:0]` = 2'b10 selects `p_out` as X and `route_mode[3:2]` = 2'b11 selects registered C as Y. The product reaches X only when `route_mode[3:0]` = 4'b0101; Z codes other than 000, 010 and 011 give zero.
- R8: `front_mode[4]` = 1 feeds the multiplier from the first B register, so a new B reaches `p_out` after three edges instead of four.
- R9: While `ce_m` is low, the product register holds. After a reset of that stage, it holds zero, so `p_out` = `carry_in` under 7'b0000101.
- R10: While `ce_p` is low, `p_out` holds its value while the operands change.
- R11: Resetting the result stage alone clears `p_out` at the next edge. The other stages keep their contents, so the product reappears one edge after release.
- R12: A negative product is sign-extended across all 48 bits of `p_out`.
- R13: Bits 29:25 of `a_in` do not reach the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_a | input | 1 | Synchronous reset, A register |
| rst_b | input | 1 | Synchronous reset, both B registers |
| rst_d | input | 1 | Synchronous reset, D register |
| rst_c | input | 1 | Synchronous reset, C register |
| rst_ad | input | 1 | Synchronous reset, pre-adder register |
| rst_m | input | 1 | Synchronous reset, product register |
| rst_p | input | 1 | Synchronous reset, result register |
| ce_a | input | 1 | Clock enable, A register |
| ce_b1 | input | 1 | Clock enable, first B register |
| ce_b2 | input | 1 | Clock enable, second B register |
| ce_d | input | 1 | Clock enable, D register |
| ce_c | input | 1 | Clock enable, C register |
| ce_ad | input | 1 | Clock enable, pre-adder register |
| ce_m | input | 1 | Clock enable, product register |
| ce_p | input | 1 | Clock enable, result register |
| a_in | input | 30 | Operand A (low 25 bits used) |
| b_in | input | 18 | Operand B, signed |
| c_in | input | 48 | Operand C |
| d_in | input | 25 | Operand D, signed |
| carry_in | input | 1 | Post-adder carry-in |
| front_mode | input | 5 | Bit 3 selects subtract, bit 4 selects early B tap |
| route_mode | input | 7 | Bits 1:0 X select, 3:2 Y select, 6:4 Z select |
| p_out | output | 48 | Result register |

## Verification
The main product path is swept over a grid of A, D and B values with both pre-adder polarities. The grid includes zero, ±1, the signed extremes of each width and A values with their upper five bits set. This separates the add and subtract paths, the wrap at 25 bits, sign extension and the dropping of the high A bits. The carry-in toggles across the grid, so a dropped or inverted carry shows up. Separate directed runs cover the other routing codes. These are all-zero routing, C as Z, C as Y and result feedback. Each of them gives a value that no other route would give, such as C + product, or 3·C after three edges. Timing-specific runs change B alone under each tap choice, and gate or reset single stages. Each run is then checked on the exact edge at which the result should move, or should not move.

// File: rtl/premul_pkg.sv
package premul_pkg;
  // X multiplexer codes (route_mode[1:0])
  localparam logic [1:0] XS_ZERO = 2'b00;
  localparam logic [1:0] XS_MULT = 2'b01;
  localparam logic [1:0] XS_PREG = 2'b10;
  // Y multiplexer codes (route_mode[3:2])
  localparam logic [1:0] YS_MULT = 2'b01;
  localparam logic [1:0] YS_CREG = 2'b11;
  // Z multiplexer codes (route_mode[6:4])
  localparam logic [2:0] ZS_ZERO = 3'b000;
  localparam logic [2:0] ZS_PREG = 3'b010;
  localparam logic [2:0] ZS_CREG = 3'b011;
  // front_mode bit positions
  localparam int FM_SUB  = 3;
  localparam int FM_BTAP = 4;
endpackage

// File: rtl/premul_reg.sv
module premul_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ce) q <= d;
  end
endmodule

// File: rtl/premul_preadd.sv
module premul_preadd #(
  parameter int AW = 30,
  parameter int DW = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          sub,
  input  logic [AW-1:0] a_q,
  input  logic [DW-1:0] d_q,
  output logic [DW-1:0] ad_q
);
  logic [DW-1:0] a_low;
  logic [DW-1:0] ad_next;
  logic          a_unused;

  assign a_low    = a_q[DW-1:0];
  assign a_unused = ^a_q[AW-1:DW];
  assign ad_next  = sub ? (d_q - a_low) : (d_q + a_low);

  premul_reg #(.W(DW)) u_ad_reg (
    .clk(clk), .rst(rst), .ce(ce), .d(ad_next), .q(ad_q)
  );
endmodule

// File: rtl/premul_mult.sv
module premul_mult #(
  parameter int PREW = 25,
  parameter int BW   = 18,
  parameter int PW   = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce,
  input  logic            early_tap,
  input  logic [PREW-1:0] ad_q,
  input  logic [BW-1:0]   b1_q,
  input  logic [BW-1:0]   b2_q,
  output logic [PW-1:0]   m_q
);
  localparam int MW = PREW + BW;

  logic [BW-1:0]        b_sel;
  logic signed [MW-1:0] prod;
  logic [PW-1:0]        prod_ext;

  assign b_sel    = early_tap ? b1_q : b2_q;
  assign prod     = $signed(ad_q) * $signed(b_sel);
  assign prod_ext = {{(PW-MW){prod[MW-1]}}, prod};

  premul_reg #(.W(PW)) u_m_reg (
    .clk(clk), .rst(rst), .ce(ce), .d(prod_ext), .q(m_q)
  );
endmodule

// File: rtl/premul_postadd.sv
module premul_postadd
  import premul_pkg::*;
#(
  parameter int PW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic [6:0]    route,
  input  logic          cin,
  input  logic [PW-1:0] m_q,
  input  logic [PW-1:0] c_q,
  output logic [PW-1:0] p_q
);
  logic [1:0]    xsel;
  logic [1:0]    ysel;
  logic [2:0]    zsel;
  logic [PW-1:0] x_val;
  logic [PW-1:0] y_val;
  logic [PW-1:0] z_val;
  logic [PW-1:0] sum;

  assign xsel = route[1:0];
  assign ysel = route[3:2];
  assign zsel = route[6:4];

  always_comb begin
    unique case (xsel)
      XS_MULT: x_val = (ysel == YS_MULT) ? m_q : '0;
      XS_PREG: x_val = p_q;
      default: x_val = '0;
    endcase
  end

  always_comb begin
    if (ysel == YS_CREG) y_val = c_q;
    else                 y_val = '0;
  end

  always_comb begin
    unique case (zsel)
      ZS_PREG: z_val = p_q;
      ZS_CREG: z_val = c_q;
      default: z_val = '0;
    endcase
  end

  assign sum = z_val + x_val + y_val + {{(PW-1){1'b0}}, cin};

  premul_reg #(.W(PW)) u_p_reg (
    .clk(clk), .rst(rst), .ce(ce), .d(sum), .q(p_q)
  );
endmodule

// File: rtl/premul_slice.sv
module premul_slice
  import premul_pkg::*;
#(
  parameter int AW = 30,
  parameter int BW = 18,
  parameter int DW = 25,
  parameter int PW = 48
) (
  input  logic          clk,
  input  logic          rst_a,
  input  logic          rst_b,
  input  logic          rst_d,
  input  logic          rst_c,
  input  logic          rst_ad,
  input  logic          rst_m,
  input  logic          rst_p,
  input  logic          ce_a,
  input  logic          ce_b1,
  input  logic          ce_b2,
  input  logic          ce_d,
  input  logic          ce_c,
  input  logic          ce_ad,
  input  logic          ce_m,
  input  logic          ce_p,
  input  logic [AW-1:0] a_in,
  input  logic [BW-1:0] b_in,
  input  logic [PW-1:0] c_in,
  input  logic [DW-1:0] d_in,
  input  logic          carry_in,
  input  logic [4:0]    front_mode,
  input  logic [6:0]    route_mode,
  output logic [PW-1:0] p_out
);
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic [BW-1:0] b1_q;
  logic [BW-1:0] b2_q;
  logic [PW-1:0] c_q;
  logic [DW-1:0] ad_q;
  logic [PW-1:0] m_q;
  logic          front_unused;

  assign front_unused = ^front_mode[2:0];

  premul_reg #(.W(AW)) u_a_reg (
    .clk(clk), .rst(rst_a), .ce(ce_a), .d(a_in), .q(a_q));
  premul_reg #(.W(DW)) u_d_reg (
    .clk(clk), .rst(rst_d), .ce(ce_d), .d(d_in), .q(d_q));
  premul_reg #(.W(BW)) u_b1_reg (
    .clk(clk), .rst(rst_b), .ce(ce_b1), .d(b_in), .q(b1_q));
  premul_reg #(.W(BW)) u_b2_reg (
    .clk(clk), .rst(rst_b), .ce(ce_b2), .d(b1_q), .q(b2_q));
  premul_reg #(.W(PW)) u_c_reg (
    .clk(clk), .rst(rst_c), .ce(ce_c), .d(c_in), .q(c_q));

  premul_preadd #(.AW(AW), .DW(DW)) u_preadd (
    .clk(clk), .rst(rst_ad), .ce(ce_ad), .sub(front_mode[FM_SUB]),
    .a_q(a_q), .d_q(d_q), .ad_q(ad_q));

  premul_mult #(.PREW(DW), .BW(BW), .PW(PW)) u_mult (
    .clk(clk), .rst(rst_m), .ce(ce_m), .early_tap(front_mode[FM_BTAP]),
    .ad_q(ad_q), .b1_q(b1_q), .b2_q(b2_q), .m_q(m_q));

  premul_postadd #(.PW(PW)) u_post (
    .clk(clk), .rst(rst_p), .ce(ce_p), .route(route_mode), .cin(carry_in),
    .m_q(m_q), .c_q(c_q), .p_q(p_out));
endmodule

// File: rtl/premul_slice_chk.sv
module premul_slice_chk #(
  parameter int PW = 48
) (
  input logic          clk,
  input logic          rst_p,
  input logic          ce_p,
  input logic          rst_m,
  input logic          ce_m,
  input logic          carry_in,
  input logic [6:0]    route_mode,
  input logic [PW-1:0] p_out,
  input logic [PW-1:0] m_q,
  input logic [PW-1:0] c_q
);
  p_reset_clear_r1: assert property (@(posedge clk) rst_p |=> p_out == '0)
    else $error("p_reset_clear_r1");

  p_zero_route_r4: assert property (@(posedge clk) disable iff (rst_p)
    (ce_p && route_mode == 7'b0000000) |=> p_out == {{(PW-1){1'b0}}, $past(carry_in)})
    else $error("p_zero_route_r4");

  p_c_as_z_r5: assert property (@(posedge clk) disable iff (rst_p)
    (ce_p && route_mode == 7'b0110000) |=> p_out == $past(c_q) + {{(PW-1){1'b0}}, $past(carry_in)})
    else $error("p_c_as_z_r5");

  p_feedback_r6: assert property (@(posedge clk) disable iff (rst_p)
    (ce_p && route_mode == 7'b0100000) |=> p_out == $past(p_out) + {{(PW-1){1'b0}}, $past(carry_in)})
    else $error("p_feedback_r6");

  p_m_hold_r9: assert property (@(posedge clk) disable iff (rst_m)
    !ce_m |=> $stable(m_q))
    else $error("p_m_hold_r9");

  p_p_hold_r10: assert property (@(posedge clk) disable iff (rst_p)
    !ce_p |=> $stable(p_out))
    else $error("p_p_hold_r10");
endmodule

bind premul_slice premul_slice_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_p(rst_p), .ce_p(ce_p), .rst_m(rst_m), .ce_m(ce_m),
  .carry_in(carry_in), .route_mode(route_mode), .p_out(p_out),
  .m_q(m_q), .c_q(c_q)
);

// File: tb/premul_slice_bench.sv
`timescale 1ns/1ps
module premul_slice_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_a, rst_b, rst_d, rst_c, rst_ad, rst_m, rst_p;
  logic ce_a, ce_b1, ce_b2, ce_d, ce_c, ce_ad, ce_m, ce_p;
  logic [29:0] a_in;
  logic [17:0] b_in;
  logic [47:0] c_in;
  logic [24:0] d_in;
  logic        carry_in;
  logic [4:0]  front_mode;
  logic [6:0]  route_mode;
  logic [47:0] p_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  premul_slice u_premul_slice (
    .clk(clk), .rst_a(rst_a), .rst_b(rst_b), .rst_d(rst_d), .rst_c(rst_c),
    .rst_ad(rst_ad), .rst_m(rst_m), .rst_p(rst_p),
    .ce_a(ce_a), .ce_b1(ce_b1), .ce_b2(ce_b2), .ce_d(ce_d), .ce_c(ce_c),
    .ce_ad(ce_ad), .ce_m(ce_m), .ce_p(ce_p),
    .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in), .carry_in(carry_in),
    .front_mode(front_mode), .route_mode(route_mode), .p_out(p_out));

  function automatic logic [47:0] expm(input logic [29:0] a, input logic [17:0] b,
                                       input logic [24:0] d, input logic sub);
    logic signed [24:0] s;
    logic signed [42:0] pr;
    s  = sub ? (d - a[24:0]) : (d + a[24:0]);
    pr = s * $signed(b);
    return {{5{pr[42]}}, pr};
  endfunction

  function automatic logic [29:0] pick_a(input int i);
    case (i)
      0: return 30'd0;        1: return 30'd1;
      2: return 30'd5;        3: return 30'h3FFFFFFF;
      4: return 30'h01000000; 5: return 30'h00FFFFFF;
      6: return 30'h3E000003; default: return 30'h2AAAAAA5;
    endcase
  endfunction

  function automatic logic [24:0] pick_d(input int i);
    case (i)
      0: return 25'd0;        1: return 25'd20;
      2: return 25'h1FFFFFF;  3: return 25'h1000000;
      4: return 25'h0FFFFFF;  5: return 25'd7;
      6: return 25'h1555555;  default: return 25'h0ABCDEF;
    endcase
  endfunction

  function automatic logic [17:0] pick_b(input int i);
    case (i)
      0: return 18'd0;      1: return 18'd1;
      2: return 18'h3FFFF;  3: return 18'd3;
      4: return 18'h1FFFF;  default: return 18'h20000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_ops(input logic [29:0] a, input logic [17:0] b, input logic [24:0] d);
    a_in = a; b_in = b; d_in = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [47:0] m;
    {rst_a, rst_b, rst_d, rst_c, rst_ad, rst_m, rst_p} = '1;
    {ce_a, ce_b1, ce_b2, ce_d, ce_c, ce_ad, ce_m, ce_p} = '1;
    set_ops('0, '0, '0);
    c_in = '0; carry_in = 0; front_mode = '0; route_mode = '0;
    step(3);
    {rst_a, rst_b, rst_d, rst_c, rst_ad, rst_m, rst_p} = '0;
    chk("R1 reset", p_out, 48'd0);

    // R12: negative product sign extension
    route_mode = 7'b0000101; front_mode = 5'b01000;
    set_ops(30'd5, 18'd3, 25'd0);
    step(4);
    chk("R12 negative", p_out, 48'hFFFF_FFFF_FFF1);

    // R13: upper A bits dropped
    set_ops(30'h3E000003, 18'd2, 25'd10);
    step(4);
    chk("R13 high A bits", p_out, 48'd14);

    // R2 / R3 sweep
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int k = 0; k < 6; k++) begin
            front_mode = {1'b0, s[0], 3'b000};
            carry_in   = ((i + j + k) % 2) == 1;
            set_ops(pick_a(i), pick_b(k), pick_d(j));
            step(4);
            chk(s ? "R2 subtract sweep" : "R3 add sweep", p_out,
                expm(pick_a(i), pick_b(k), pick_d(j), s[0]) + {47'd0, carry_in});
          end

    // R4: all-zero routing
    route_mode = 7'b0000000; carry_in = 1;
    set_ops(30'd3, 18'd9, 25'd100);
    step(4);
    chk("R4 zero route cin=1", p_out, 48'd1);
    carry_in = 0;
    step(1);
    chk("R4 zero route cin=0", p_out, 48'd0);

    // R5: C as Z plus product
    front_mode = 5'b01000; route_mode = 7'b0110101; carry_in = 1;
    c_in = 48'h0123_4567_89AB;
    set_ops(30'd3, 18'd9, 25'd100);
    step(4);
    chk("R5 C+M+cin", p_out, 48'h0123_4567_89AB + 48'd874);

    // R7: X = P, Y = C accumulation
    route_mode = 7'b0000000; carry_in = 0; c_in = 48'd1000;
    step(2);
    route_mode = 7'b0001110;
    step(1);
    chk("R7 P+C first", p_out, 48'd1000);
    step(2);
    chk("R7 P+C third", p_out, 48'd3000);
    route_mode = 7'b0000001;
    step(1);
    chk("R7 X=M needs Y=01", p_out, 48'd0);

    // R6: Z = P feedback with product
    route_mode = 7'b0000101; carry_in = 0;
    set_ops(30'd2, 18'd4, 25'd9);
    step(4);
    chk("R6 base", p_out, 48'd28);
    route_mode = 7'b0100101; carry_in = 1;
    step(1);
    chk("R6 accumulate 1", p_out, 48'd57);
    step(1);
    chk("R6 accumulate 2", p_out, 48'd86);

    // R8: early B tap latency
    route_mode = 7'b0000101; carry_in = 0; front_mode = 5'b11000;
    set_ops(30'd0, 18'd2, 25'd10);
    step(5);
    chk("R8 early base", p_out, 48'd20);
    b_in = 18'd3;
    step(2);
    chk("R8 early not yet", p_out, 48'd20);
    step(1);
    chk("R8 early at 3", p_out, 48'd30);
    front_mode = 5'b01000; b_in = 18'd2;
    step(5);
    b_in = 18'd5;
    step(3);
    chk("R8 late not at 3", p_out, 48'd20);
    step(1);
    chk("R8 late at 4", p_out, 48'd50);

    // R9: product register gated after reset
    rst_m = 1;
    step(1);
    rst_m = 0; ce_m = 0; carry_in = 1;
    step(1);
    chk("R9 M zero", p_out, 48'd1);
    set_ops(30'd1, 18'd7, 25'd8);
    step(4);
    chk("R9 M held", p_out, 48'd1);
    ce_m = 1; carry_in = 0;
    step(2);
    chk("R9 M released", p_out, 48'd49);

    // R10: result gated
    ce_p = 0;
    set_ops(30'd0, 18'd11, 25'd11);
    step(4);
    chk("R10 P held", p_out, 48'd49);
    ce_p = 1;
    step(1);
    chk("R10 P released", p_out, 48'd121);

    // R11: result-only reset
    rst_p = 1;
    step(1);
    chk("R11 P cleared", p_out, 48'd0);
    rst_p = 0;
    step(1);
    chk("R11 P recovers", p_out, 48'd121);

    finish_run();
  end
endmodule